// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns a read or write column command into the ordered stream of column addresses for one burst of a double-data-rate array that fetches two words per clock. When a start strobe is sampled it latches the starting column, the burst length and the burst ordering. From the next cycle on it presents two column addresses per clock: the even beat on one output and the following odd beat on the other.

Two orderings are provided. Sequential ordering counts upward from the start and wraps inside the aligned block of the burst length. Interleaved ordering forms each beat's low bits as the start XOR'd with the beat number. Column bits above the block never change. A stop strobe cuts the burst short. A new start strobe in the middle of a burst abandons the old burst and begins a new one at the new column. The controller above drives these strobes; bank, row, data and latency handling live elsewhere.

Top module: `burst_col_gen`

## Requirements
- R1: The length code `bl_code` selects the burst length: 0 gives 2 beats, 1 gives 4, 2 gives 8, 3 gives 16. `valid` stays high for exactly length/2 consecutive cycles after a start, unless the burst is cut short.
- R2: With `interleave` = 0 (sequential), beat i has low bits equal to (start + i) mod length. For example, start 5 at length 8 gives 5,6,7,0,1,2,3,4.
- R3: With `interleave` = 1, beat i has low bits equal to start XOR i. For example, start 5 at length 8 gives 5,4,7,6,1,0,3,2. Start 9 at length 16 gives 9,8,11,10,13,12,15,14,1,0,3,2,5,4,7,6.
- R4: The column bits above log2(length) equal those of the starting column for every beat. The wrap never carries into them.
- R5: In the k-th valid cycle after the start (k counted from 0), `col_even` carries beat 2k and `col_odd` carries beat 2k+1. Pair 0 appears in the cycle right after the start strobe is sampled.
- R6: `last` is high only together with `valid`, and only on the final pair of a burst.
- R7: If `stop` is sampled without `start`, `valid` and `last` are low from the next cycle.
- R8: If `start` is sampled during a burst, the next cycle shows pair 0 of the new burst. `start` takes priority over a `stop` sampled in the same cycle.
- R9: The length code and ordering are latched at the start strobe. Changes to `bl_code` or `interleave` during a burst do not alter that burst's addresses or its length.
- R10: While reset is asserted, and after it is released until the first start, `valid` and `last` are low.
- R11: After the final pair, if no start was sampled, `valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | COL_W (10) | Starting column of the burst |
| bl_code | input | CODE_W (2) | Burst length code (0:2, 1:4, 2:8, 3:16) |
| interleave | input | 1 | 0 = sequential ordering, 1 = interleaved ordering |
| stop | input | 1 | End the current burst |
| col_even | output | COL_W (10) | Column of beat 2k |
| col_odd | output | COL_W (10) | Column of beat 2k+1 |
| valid | output | 1 | Column pair is valid this cycle |
| last | output | 1 | This is the final pair of the burst |

## Verification
A stop and a new start can reach the block in the same cycle. A start can also land on the very cycle that shows a burst's final pair, so that a burst's end and the next burst's beginning meet. The bench provokes both directly, and random traffic provokes them again by drawing start and stop independently in each cycle. Each outcome is judged against a bench model in which start outranks stop: the cycle after the collision must show pair 0 of the new burst, with its own latched length and ordering.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

   // Ordering selector values, as seen on the interleave input
   typedef enum logic {
      ORD_SEQ = 1'b0,
      ORD_XOR = 1'b1
   } order_e;

   // Length code to log2(burst length): code c gives 2^(c+1) beats
   function automatic int unsigned code_to_log2(input int unsigned code);
      return code + 1;
   endfunction

endpackage

// File: rtl/burst_col_seq.sv
// Burst sequencer: latches the command, counts column pairs, flags the final one
module burst_col_seq
   import burst_col_pkg::*;
#(
   parameter int COL_W       = 10,
   parameter int MAX_BL_LOG2 = 4,
   localparam int CODE_W     = (MAX_BL_LOG2 > 2) ? $clog2(MAX_BL_LOG2) : 1,
   localparam int LOG_W      = $clog2(MAX_BL_LOG2 + 1),
   localparam int PAIR_W     = MAX_BL_LOG2 - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [COL_W-1:0]  start_col,
   input  logic [CODE_W-1:0] bl_code,
   input  logic              interleave,
   input  logic              stop,
   output logic              active,
   output logic [COL_W-1:0]  base_col,
   output logic [LOG_W-1:0]  bl_log2,
   output order_e            order,
   output logic [PAIR_W-1:0] pair_idx,
   output logic              last_pair
);

   logic [LOG_W-1:0]  req_log2;
   logic [PAIR_W-1:0] final_idx;

   // Codes beyond the largest supported length saturate to the maximum
   always_comb begin
      if (int'(bl_code) + 1 > MAX_BL_LOG2)
         req_log2 = LOG_W'(MAX_BL_LOG2);
      else
         req_log2 = LOG_W'(code_to_log2(int'(bl_code)));
   end

   assign final_idx = PAIR_W'((1 << (int'(bl_log2) - 1)) - 1);
   assign last_pair = active && (pair_idx == final_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         base_col <= '0;
         bl_log2  <= LOG_W'(1);
         order    <= ORD_SEQ;
         pair_idx <= '0;
      end else if (start) begin
         active   <= 1'b1;
         base_col <= start_col;
         bl_log2  <= req_log2;
         order    <= order_e'(interleave);
         pair_idx <= '0;
      end else if (stop || last_pair) begin
         active   <= 1'b0;
         pair_idx <= '0;
      end else if (active) begin
         pair_idx <= pair_idx + PAIR_W'(1);
      end
   end

endmodule

// File: rtl/burst_col_lane.sv
// One address lane: column of a given beat number within the wrap block
module burst_col_lane
   import burst_col_pkg::*;
#(
   parameter int COL_W       = 10,
   parameter int MAX_BL_LOG2 = 4,
   localparam int LOG_W      = $clog2(MAX_BL_LOG2 + 1)
) (
   input  logic [COL_W-1:0]       base_col,
   input  logic [LOG_W-1:0]       bl_log2,
   input  order_e                 order,
   input  logic [MAX_BL_LOG2-1:0] beat,
   output logic [COL_W-1:0]       col
);

   logic [COL_W-1:0] blk_mask;
   logic [COL_W-1:0] beat_ext;
   logic [COL_W-1:0] low_bits;

   assign blk_mask = (COL_W'(1) << bl_log2) - COL_W'(1);
   assign beat_ext = COL_W'(beat);

   always_comb begin
      case (order)
         ORD_XOR: low_bits = base_col ^ beat_ext;
         default: low_bits = base_col + beat_ext;
      endcase
   end

   assign col = (base_col & ~blk_mask) | (low_bits & blk_mask);

endmodule

// File: rtl/burst_col_gen.sv
// Top: burst column generator, two columns per clock
module burst_col_gen
   import burst_col_pkg::*;
#(
   parameter int COL_W       = 10,
   parameter int MAX_BL_LOG2 = 4,
   localparam int CODE_W     = (MAX_BL_LOG2 > 2) ? $clog2(MAX_BL_LOG2) : 1,
   localparam int LOG_W      = $clog2(MAX_BL_LOG2 + 1),
   localparam int PAIR_W     = MAX_BL_LOG2 - 1,
   localparam int LANES      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [COL_W-1:0]  start_col,
   input  logic [CODE_W-1:0] bl_code,
   input  logic              interleave,
   input  logic              stop,
   output logic [COL_W-1:0]  col_even,
   output logic [COL_W-1:0]  col_odd,
   output logic              valid,
   output logic              last
);

   // Elaboration-time parameter checks
   if (MAX_BL_LOG2 < 2) begin : g_bad_len
      $error("MAX_BL_LOG2 must be at least 2");
   end
   if (COL_W < MAX_BL_LOG2) begin : g_bad_col
      $error("COL_W must cover the largest burst block");
   end

   logic              active;
   logic [COL_W-1:0]  base_col;
   logic [LOG_W-1:0]  bl_log2;
   order_e            order;
   logic [PAIR_W-1:0] pair_idx;
   logic              last_pair;
   logic [COL_W-1:0]  lane_col [LANES];

   burst_col_seq #(
      .COL_W       (COL_W),
      .MAX_BL_LOG2 (MAX_BL_LOG2)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_col  (start_col),
      .bl_code    (bl_code),
      .interleave (interleave),
      .stop       (stop),
      .active     (active),
      .base_col   (base_col),
      .bl_log2    (bl_log2),
      .order      (order),
      .pair_idx   (pair_idx),
      .last_pair  (last_pair)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [MAX_BL_LOG2-1:0] beat;
      assign beat = {pair_idx, 1'(g)};
      burst_col_lane #(
         .COL_W       (COL_W),
         .MAX_BL_LOG2 (MAX_BL_LOG2)
      ) u_lane (
         .base_col (base_col),
         .bl_log2  (bl_log2),
         .order    (order),
         .beat     (beat),
         .col      (lane_col[g])
      );
   end

   assign col_even = lane_col[0];
   assign col_odd  = lane_col[1];
   assign valid    = active;
   assign last     = last_pair;

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
   parameter int COL_W       = 10,
   parameter int MAX_BL_LOG2 = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             stop,
   input logic             valid,
   input logic             last,
   input logic [COL_W-1:0] col_even,
   input logic [COL_W-1:0] col_odd
);

   // R6: last only accompanies a valid pair
   a_r6_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      last |-> valid);

   // R7: a lone stop ends the burst in the next cycle
   a_r7_stop_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !start) |=> !valid);

   // R8: a start always yields a valid pair next cycle
   a_r8_start_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> valid);

   // R11: after the final pair without a new start, valid falls
   a_r11_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !start) |=> !valid);

   // R1: an uninterrupted burst keeps going until its last pair
   a_r1_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !last && !stop && !start) |=> valid);

   // R5: the two beats of a pair differ in bit 0 under both orderings
   a_r5_pair_parity: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (col_even[0] != col_odd[0]));

   // R4: bits above the largest block stay fixed within a burst
   a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !last && !stop && !start) |=>
         (col_even[COL_W-1:MAX_BL_LOG2] == $past(col_even[COL_W-1:MAX_BL_LOG2])));

endmodule

bind burst_col_gen burst_col_gen_chk #(
   .COL_W       (COL_W),
   .MAX_BL_LOG2 (MAX_BL_LOG2)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .stop     (stop),
   .valid    (valid),
   .last     (last),
   .col_even (col_even),
   .col_odd  (col_odd)
);

// File: tb/burst_col_gen_bench.sv
`timescale 1ns/1ps
module burst_col_gen_bench;

   localparam int COL_W = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [COL_W-1:0] start_col = '0;
   logic [1:0]       bl_code = '0;
   logic             interleave = 1'b0;
   logic             stop = 1'b0;
   logic [COL_W-1:0] col_even, col_odd;
   logic             valid, last;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   string cur_tag = "R10";

   // bench model state
   bit               m_act = 1'b0;
   logic [COL_W-1:0] m_col = '0;
   int               m_log = 1;
   bit               m_il = 1'b0;
   int               m_k = 0;

   always #2.5 clk = ~clk;

   burst_col_gen u_burst_col_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_col  (start_col),
      .bl_code    (bl_code),
      .interleave (interleave),
      .stop       (stop),
      .col_even   (col_even),
      .col_odd    (col_odd),
      .valid      (valid),
      .last       (last)
   );

   function automatic logic [COL_W-1:0] exp_col(logic [COL_W-1:0] s, int lg, bit il, int beat);
      logic [COL_W-1:0] mask, low;
      mask = (COL_W'(1) << lg) - COL_W'(1);
      low  = il ? (s ^ COL_W'(beat)) : (s + COL_W'(beat));
      return (s & ~mask) | (low & mask);
   endfunction

   function automatic bit m_last();
      return m_act && (m_k == (1 << (m_log - 1)) - 1);
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic compare();
      chk(cur_tag, "valid", int'(valid), int'(m_act));
      chk("R6", "last", int'(last), int'(m_last()));
      if (m_act) begin
         chk(cur_tag, "col_even", int'(col_even), int'(exp_col(m_col, m_log, m_il, 2*m_k)));
         chk(cur_tag, "col_odd", int'(col_odd), int'(exp_col(m_col, m_log, m_il, 2*m_k+1)));
      end
   endtask

   task automatic model_step();
      if (start) begin
         m_act = 1'b1; m_col = start_col; m_log = int'(bl_code) + 1;
         m_il = interleave; m_k = 0;
      end else if (stop || m_last()) begin
         m_act = 1'b0; m_k = 0;
      end else if (m_act) begin
         m_k++;
      end
   endtask

   // one cycle: check at the falling edge, drive, advance the model
   task automatic cyc(bit s, logic [COL_W-1:0] c, logic [1:0] code, bit il, bit stp);
      @(negedge clk);
      compare();
      start = s; start_col = c; bl_code = code; interleave = il; stop = stp;
      model_step();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0, start_col, bl_code, interleave, 0);
   endtask

   initial begin
      void'($urandom(32'h5EED));
      // R10: reset state
      cur_tag = "R10";
      repeat (3) @(negedge clk);
      chk("R10", "valid in reset", int'(valid), 0);
      chk("R10", "last in reset", int'(last), 0);
      rst_n = 1'b1;
      idle(2);

      // R1: all four lengths, sequential from 0
      cur_tag = "R1";
      for (int code = 0; code < 4; code++) begin
         cyc(1, 10'h040, 2'(code), 0, 0);
         idle(10);
      end

      // R2: sequential example start 5, length 8
      cur_tag = "R2";
      cyc(1, 10'h005, 2'd2, 0, 0);
      idle(5);
      // R3: interleaved examples
      cur_tag = "R3";
      cyc(1, 10'h005, 2'd2, 1, 0);
      idle(5);
      cyc(1, 10'h009, 2'd3, 1, 0);
      idle(9);

      // R4: wrap at the top of the column space keeps upper bits
      cur_tag = "R4";
      cyc(1, 10'h3FD, 2'd1, 0, 0);
      idle(3);
      cyc(1, 10'h2B7, 2'd3, 0, 0);
      idle(9);

      // R5: pairing of beats, odd start in a 16-beat sequential burst
      cur_tag = "R5";
      cyc(1, 10'h10B, 2'd3, 0, 0);
      idle(9);

      // R7: stop mid-burst
      cur_tag = "R7";
      cyc(1, 10'h0A3, 2'd3, 1, 0);
      idle(2);
      cyc(0, 10'h0A3, 2'd3, 1, 1);
      idle(3);

      // R8: restart mid-burst, restart with simultaneous stop, restart on last pair
      cur_tag = "R8";
      cyc(1, 10'h011, 2'd3, 0, 0);
      idle(2);
      cyc(1, 10'h1F6, 2'd2, 1, 0);
      idle(1);
      cyc(1, 10'h333, 2'd1, 0, 1);
      idle(1);
      cyc(1, 10'h07E, 2'd0, 1, 0);
      idle(3);

      // R9: mode inputs change during the burst
      cur_tag = "R9";
      cyc(1, 10'h0C6, 2'd3, 0, 0);
      for (int i = 0; i < 8; i++) cyc(0, 10'h3FF, 2'(i), ~i[0], 0);
      idle(2);

      // R11: gap after a natural end
      cur_tag = "R11";
      cyc(1, 10'h222, 2'd0, 0, 0);
      idle(4);

      // random traffic
      cur_tag = "R2";
      for (int i = 0; i < 4000; i++) begin
         bit s, p, il;
         s  = ($urandom % 6) == 0;
         p  = ($urandom % 20) == 0;
         il = 1'($urandom);
         cur_tag = m_il ? "R3" : "R2";
         cyc(s, COL_W'($urandom), 2'($urandom), il, p);
      end
      idle(10);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule